// File: doc/BRIEF.md
# Multiphase PWM Phase Generator

This block drives up to four digital PWM channels from one shared period counter. All channels switch at the same frequency. The start of each channel's period is placed so that the active channels are spread evenly over one switching period. Each channel has a level output and an output-enable output. When the enable is low, the pin is meant to float.

The number of active channels is not set by a register. It is learned while reset is held: any channel whose `unusedIn` bit is high at that time is excluded. The remaining channels are ranked in index order, and the period is divided by their count. Each channel has its own duty word, which a surrounding current-balance loop can adjust. A duty word is captured only when that channel's own period begins.

A global `enable` clamps every level low without floating the pins. `tristateReq` floats all outputs.

Top module: `mphase_pwm`

## Requirements
- R1: The block has NUM_CH (default 4) channels, each with one `pwmOut` bit and one `pwmOe` bit. Channel i uses bits `dutyIn[i*DUTY_W +: DUTY_W]`.
- R2: `unusedIn` is sampled on every clock edge while `rstN` is low and is frozen afterwards. A later change of `unusedIn` has no effect on the set of active channels or on their phases.
- R3: Active channels are ranked by ascending index, and the lowest active index has rank 0. A channel of rank k starts its period k*PERIOD/N clocks after rank 0, where N is the active count.
- R4: Over any PERIOD consecutive clocks, with every active duty word in 1..PERIOD-1, the total count of rising edges across all `pwmOut` bits equals N.
- R5: While `rstN` is low, `pwmOe` and `pwmOut` are all zero.
- R6: A channel marked unused keeps `pwmOe` and `pwmOut` at zero for as long as reset stays released.
- R7: When `tristateReq` is high at a clock edge, every `pwmOe` and `pwmOut` bit is zero after that edge. When it is low, each active channel's `pwmOe` is one after the edge.
- R8: For a duty word D in 0..PERIOD-1, an active channel is high for exactly D clocks in each of its periods. D = 0 gives a constant low.
- R9: A duty word of PERIOD or more keeps an active channel constantly high, with no falling edge.
- R10: A duty word is taken only at the start of the channel's own period. A change in mid-period leaves the current pulse width unchanged and applies from the next period.
- R11: With `enable` low at a clock edge, all `pwmOut` bits are zero after it, while `pwmOe` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also floats the outputs directly |
| enable | input | 1 | Run enable; low clamps the levels low |
| tristateReq | input | 1 | Float all outputs |
| unusedIn | input | NUM_CH | Per-channel unused marks, captured during reset |
| dutyIn | input | NUM_CH*DUTY_W | Packed per-channel duty words, in clocks |
| pwmOut | output | NUM_CH | PWM levels |
| pwmOe | output | NUM_CH | Per-channel output enables |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `unusedIn` holds steady for the last cycles of reset, and that PERIOD divides evenly by 1 through 4. The bench changes inputs only at falling edges. It applies a new unused pattern only inside a reset pulse of several cycles. All duty values it uses fit in DUTY_W bits. It lets at least two full periods pass before measuring, so that every channel has latched its current duty word.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CH_MAX = 4;

  // strobes passed from the control to the datapath
  typedef struct packed {
    logic [CH_MAX-1:0] chanStart;  // channel period begins this cycle
    logic [CH_MAX-1:0] chanLive;   // channel is in use
    logic              hiZ;        // float all outputs
  } pwmCtrl_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PERIOD = 240,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] unusedIn,
  input  logic              tristateReq,
  output pwmCtrl_t          ctrlOut
);
  logic [NUM_CH-1:0] unusedQ;
  logic [CNT_W-1:0]  periodCnt;
  logic [CNT_W-1:0]  offsetArr [NUM_CH];
  int                activeCnt;

  // the unused marks are followed while in reset and then held
  always_ff @(posedge clk) begin
    if (!rstN) unusedQ <= unusedIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                periodCnt <= '0;
    else if (periodCnt == CNT_W'(PERIOD - 1)) periodCnt <= '0;
    else                                      periodCnt <= periodCnt + 1'b1;
  end

  function automatic int slotLen(input int n);
    case (n)
      2:       return PERIOD / 2;
      3:       return PERIOD / 3;
      4:       return PERIOD / 4;
      default: return PERIOD;
    endcase
  endfunction

  always_comb begin
    activeCnt = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!unusedQ[i]) activeCnt = activeCnt + 1;
    end
  end

  // rank active channels in index order; offset = rank * slot
  always_comb begin
    int rank;
    rank = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      offsetArr[i] = CNT_W'(rank * slotLen(activeCnt));
      if (!unusedQ[i]) rank = rank + 1;
    end
  end

  always_comb begin
    ctrlOut     = '0;
    ctrlOut.hiZ = tristateReq;
    for (int i = 0; i < NUM_CH; i++) begin
      ctrlOut.chanLive[i]  = !unusedQ[i];
      ctrlOut.chanStart[i] = rstN && !unusedQ[i] && (periodCnt == offsetArr[i]);
    end
  end
endmodule

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PERIOD = 240,
  parameter int DUTY_W = 9,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [NUM_CH*DUTY_W-1:0] dutyIn,
  input  pwmCtrl_t                 ctrlIn,
  output logic [NUM_CH-1:0]        levelOut,
  output logic [NUM_CH-1:0]        oeOut
);
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [CNT_W-1:0]  phaseCnt;
    logic [DUTY_W-1:0] dutyQ;
    logic [DUTY_W-1:0] dutyNow;
    logic              levelBit;
    logic              oeBit;

    assign dutyNow = dutyIn[g*DUTY_W +: DUTY_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        phaseCnt <= '0;
        dutyQ    <= '0;
        levelBit <= 1'b0;
        oeBit    <= 1'b0;
      end else begin
        oeBit <= ctrlIn.chanLive[g] && !ctrlIn.hiZ;
        if (ctrlIn.chanStart[g]) begin
          dutyQ    <= dutyNow;
          phaseCnt <= CNT_W'(1);
          levelBit <= enable && (dutyNow != '0);
        end else begin
          if (phaseCnt != CNT_W'(PERIOD - 1)) phaseCnt <= phaseCnt + 1'b1;
          levelBit <= enable && ctrlIn.chanLive[g] && (int'(phaseCnt) < int'(dutyQ));
        end
      end
    end

    assign levelOut[g] = levelBit;
    assign oeOut[g]    = oeBit;
  end
endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PERIOD = 240,
  parameter int DUTY_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     tristateReq,
  input  logic [NUM_CH-1:0]        unusedIn,
  input  logic [NUM_CH*DUTY_W-1:0] dutyIn,
  output logic [NUM_CH-1:0]        pwmOut,
  output logic [NUM_CH-1:0]        pwmOe
);
  localparam int CNT_W = $clog2(PERIOD);

  pwmCtrl_t          ctrlBus;
  logic [NUM_CH-1:0] levelQ;
  logic [NUM_CH-1:0] oeQ;

  mpwm_ctrl #(.NUM_CH(NUM_CH), .PERIOD(PERIOD), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .unusedIn(unusedIn),
    .tristateReq(tristateReq), .ctrlOut(ctrlBus)
  );

  mpwm_datapath #(.NUM_CH(NUM_CH), .PERIOD(PERIOD), .DUTY_W(DUTY_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .enable(enable), .dutyIn(dutyIn),
    .ctrlIn(ctrlBus), .levelOut(levelQ), .oeOut(oeQ)
  );

  // reset floats the pins without waiting for a clock edge
  assign pwmOe  = oeQ & {NUM_CH{rstN}};
  assign pwmOut = levelQ & pwmOe;
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
  import mpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DUTY_W = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     enable,
  input logic                     tristateReq,
  input logic [NUM_CH*DUTY_W-1:0] dutyIn,
  input logic [NUM_CH-1:0]        pwmOut,
  input logic [NUM_CH-1:0]        pwmOe,
  input pwmCtrl_t                 ctrlBus
);
  assert_reset_float_R5: assert property (@(posedge clk)
    !rstN |-> (pwmOe == '0 && pwmOut == '0));

  assert_tristate_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    tristateReq |=> (pwmOe == '0 && pwmOut == '0));

  assert_enable_clamp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == '0));

  assert_distinct_starts_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlBus.chanStart));

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    assert_zero_duty_R8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlBus.chanStart[g] && dutyIn[g*DUTY_W +: DUTY_W] == '0) |=> !pwmOut[g]);

    assert_unused_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlBus.chanLive[g] |-> (!pwmOe[g] && !pwmOut[g]));
  end
endmodule

bind mphase_pwm mpwm_checker #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .tristateReq(tristateReq),
  .dutyIn(dutyIn), .pwmOut(pwmOut), .pwmOe(pwmOe), .ctrlBus(ctrlBus)
);

// File: tb/sim_mphase_pwm.sv
`timescale 1ns/1ps
module sim_mphase_pwm;
  localparam int NCH = 4;
  localparam int PER = 240;
  localparam int DW  = 9;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b1;
  logic            tristateReq = 1'b0;
  logic [NCH-1:0]  unusedIn = '0;
  logic [NCH*DW-1:0] dutyIn = '0;
  logic [NCH-1:0]  pwmOut;
  logic [NCH-1:0]  pwmOe;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleIdx = 0;
  int riseCnt  [NCH];
  int highCnt  [NCH];
  int riseAt   [NCH];
  logic [NCH-1:0] prevOut = '0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  mphase_pwm #(.NUM_CH(NCH), .PERIOD(PER), .DUTY_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .tristateReq(tristateReq),
    .unusedIn(unusedIn), .dutyIn(dutyIn), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always @(negedge clk) begin
    cycleIdx++;
    for (int c = 0; c < NCH; c++) begin
      if (pwmOut[c]) highCnt[c]++;
      if (pwmOut[c] && !prevOut[c]) begin
        riseCnt[c]++;
        riseAt[c] = cycleIdx;
      end
    end
    prevOut = pwmOut;
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setDuty(input int ch, input int val);
    dutyIn[ch*DW +: DW] = DW'(val);
  endtask

  task automatic doReset(input logic [NCH-1:0] pat);
    @(negedge clk);
    rstN = 1'b0;
    unusedIn = pat;
    repeat (4) @(negedge clk);
    checkEq("R5 oe in reset", int'(pwmOe), 0);
    checkEq("R5 out in reset", int'(pwmOut), 0);
    rstN = 1'b1;
  endtask

  task automatic measurePeriod();
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      riseCnt[c] = 0; highCnt[c] = 0; riseAt[c] = 0;
    end
    repeat (PER) @(posedge clk);
    #1;
  endtask

  function automatic int phaseDiff(input int a, input int b);
    return (((riseAt[a] - riseAt[b]) % PER) + PER) % PER;
  endfunction

  function automatic int totalRises();
    int s = 0;
    for (int c = 0; c < NCH; c++) s += riseCnt[c];
    return s;
  endfunction

  task automatic testFourPhase();
    for (int c = 0; c < NCH; c++) setDuty(c, 60);
    doReset(4'b0000);
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R1 four enables", int'(pwmOe), 15);
    for (int c = 0; c < NCH; c++) checkEq("R8 width 60", highCnt[c], 60);
    checkEq("R4 ripple four", totalRises(), 4);
    for (int c = 1; c < NCH; c++) checkEq("R3 quarter spacing", phaseDiff(c, 0), c * 60);
  endtask

  task automatic testThreePhase();
    for (int c = 0; c < NCH; c++) setDuty(c, 100);
    doReset(4'b0010);
    @(negedge clk);
    unusedIn = 4'b0000;   // R2: must be ignored outside reset
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R2 mask frozen", int'(pwmOe), 13);
    checkEq("R6 unused quiet", highCnt[1], 0);
    checkEq("R4 ripple three", totalRises(), 3);
    checkEq("R3 third spacing ch2", phaseDiff(2, 0), 80);
    checkEq("R3 third spacing ch3", phaseDiff(3, 0), 160);
  endtask

  task automatic testTwoAndOne();
    for (int c = 0; c < NCH; c++) setDuty(c, 50);
    doReset(4'b1010);
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R3 half spacing", phaseDiff(2, 0), 120);
    checkEq("R4 ripple two", totalRises(), 2);
    checkEq("R6 two active enables", int'(pwmOe), 5);
    doReset(4'b1110);
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R4 ripple one", totalRises(), 1);
    checkEq("R6 one active enable", int'(pwmOe), 1);
  endtask

  task automatic testDutyLimits();
    setDuty(0, 0); setDuty(1, 300); setDuty(2, 1); setDuty(3, 239);
    doReset(4'b0000);
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R8 zero duty low", highCnt[0], 0);
    checkEq("R9 full duty high", highCnt[1], PER);
    checkEq("R9 no edge at full duty", riseCnt[1], 0);
    checkEq("R8 width 1", highCnt[2], 1);
    checkEq("R8 width 239", highCnt[3], 239);
  endtask

  task automatic testMidChange();
    int width;
    setDuty(0, 100);
    repeat (2 * PER) @(negedge clk);
    while (pwmOut[0]) @(negedge clk);
    while (!pwmOut[0]) @(negedge clk);
    width = 0;
    while (pwmOut[0]) begin
      width++;
      if (width == 10) setDuty(0, 20);
      @(negedge clk);
    end
    checkEq("R10 current pulse kept", width, 100);
    while (!pwmOut[0]) @(negedge clk);
    width = 0;
    while (pwmOut[0]) begin
      width++;
      @(negedge clk);
    end
    checkEq("R10 next pulse new", width, 20);
  endtask

  task automatic testTristate();
    @(negedge clk);
    tristateReq = 1'b1;
    @(negedge clk);
    checkEq("R7 enables off", int'(pwmOe), 0);
    checkEq("R7 levels off", int'(pwmOut), 0);
    tristateReq = 1'b0;
    @(negedge clk);
    checkEq("R7 enables back", int'(pwmOe), 15);
  endtask

  task automatic testEnable();
    for (int c = 0; c < NCH; c++) setDuty(c, 40);
    repeat (2 * PER) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    checkEq("R11 levels low", int'(pwmOut), 0);
    measurePeriod();
    checkEq("R11 enables kept", int'(pwmOe), 15);
    checkEq("R11 no high time", highCnt[0] + highCnt[1] + highCnt[2] + highCnt[3], 0);
    @(negedge clk);
    enable = 1'b1;
    repeat (2 * PER) @(negedge clk);
    measurePeriod();
    checkEq("R11 resumes width", highCnt[2], 40);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      riseCnt[c] = 0; highCnt[c] = 0; riseAt[c] = 0;
    end
    testFourPhase();
    testThreePhase();
    testTwoAndOne();
    testDutyLimits();
    testMidChange();
    testTristate();
    testEnable();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule